// File: doc/BRIEF.md
# Four-Phase Instruction Pipeline Sequencer

This block sets the timing for a small core that uses 12-bit instruction words. It divides the incoming oscillator clock into four phase strobes. Exactly one strobe is active on each input clock, so one instruction cycle lasts four input clocks. The block also runs a two-stage pipeline. While the instruction fetched in the previous cycle executes, the next word is read from program memory. The sequencer owns the program counter. It tells the surrounding core when to read data memory, when to write it, and when the instruction register takes a new word.

The executing instruction can report a taken branch together with a target address. In that case the sequencer loads the target into the program counter and discards the word already prefetched. It then spends one cycle fetching the target. During that cycle nothing executes: no data-memory strobes fire and the program counter does not step. After reset, the first cycle only fetches and does not execute.

Program memory is assumed to be an asynchronous read port. The word for `pm_addr` must be valid on `pm_data` by the end of the fourth phase. `PM_WORDS` must be a power of two.

Top module: `qseq_core`

## Requirements
- R1: `phase` is one-hot on every clock after reset. Bit 0 is Q1, bit 1 is Q2, bit 2 is Q3 and bit 3 is Q4. The active bit advances one position per input clock and returns from Q4 to Q1.
- R2: `clkout` is high during Q1 and Q2 and low during Q3 and Q4.
- R3: Reset is synchronous and active low. While it is applied, and on the first clock after it is released, the block shows `phase`=Q1, `pm_addr`=`RESET_VEC` (default 0x3FF), `exec_live`=0 and `ir`=0.
- R4: In a cycle with `exec_live`=1, `pc_inc` pulses during Q1 and `pm_addr` advances by one, modulo `PM_WORDS`, at the end of Q1. `pm_addr` does not change at the ends of Q2 and Q3.
- R5: `ir_load` pulses during Q4 of every cycle. At the end of Q4, `ir` captures `pm_data`, which holds the word at the `pm_addr` shown during Q2–Q4. At all other times `ir` holds its value.
- R6: `dm_rd` is high only during Q2 and `dm_wr` only during Q4, and each only while `exec_live`=1.
- R7: The first instruction cycle after reset only fetches. `exec_live` is 0, there is no `pc_inc`, no data-memory strobe fires, and the word at `RESET_VEC` is fetched.
- R8: If `br_taken`=1 at the end of Q4 in a cycle with `exec_live`=1, `pm_addr` becomes `br_target` at that edge. The next cycle is a flush cycle: `exec_live`=0, no `pc_inc`, no data-memory strobes, and the prefetched word is discarded. The target is fetched during the flush cycle and executes in the cycle after it.
- R9: `br_taken` and `br_target` have no effect in a cycle with `exec_live`=0, whether that is a flush cycle or the first cycle after reset.
- R10: Without branches, one instruction executes per cycle. The word in `ir` during a cycle is the word fetched in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, four per instruction cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| pm_addr | output | AW (10) | Program counter, used as the program-memory address |
| pm_data | input | IW (12) | Program-memory word at `pm_addr` |
| br_taken | input | 1 | The executing instruction loads the program counter |
| br_target | input | AW (10) | Branch destination address |
| phase | output | 4 | One-hot phase strobes, bit 0 = Q1 |
| clkout | output | 1 | Quarter-rate clock, high for Q1–Q2 |
| pc_inc | output | 1 | Program-counter increment strobe (Q1) |
| ir_load | output | 1 | Instruction-register load strobe (Q4) |
| ir | output | IW (12) | Instruction register |
| exec_live | output | 1 | High when `ir` holds an instruction that executes this cycle |
| dm_rd | output | 1 | Data-memory operand read strobe (Q2) |
| dm_wr | output | 1 | Data-memory destination write strobe (Q4) |

## Verification
The bench starts execution at the top address, so the first increment must wrap to zero. A counter that saturates, or that does not wrap, shows the wrong fetch address in the second cycle. It also drives `br_taken` during the fetch-only cycle and during a flush cycle. A design that honours either one jumps to a bogus address, or goes on to flush a second time. It then issues a branch to the address that would have come next anyway. A design that skips the flush for such a branch, or that still steps the program counter in the flush Q1, shows `exec_live` high one cycle early or fetches the wrong word. Finally, a write strobe that leaks into a flush cycle, or a strobe placed in the wrong phase, fails the per-phase strobe checks in every cycle of the run.

// File: rtl/qseq_pkg.sv
// Shared constants for the four-phase sequencer.
// Assumes exactly four phases per instruction cycle; index 0 is Q1.
package qseq_pkg;
    localparam int NUM_PH = 4;
    localparam int PH_W   = $clog2(NUM_PH);

    typedef logic [PH_W-1:0] ph_idx_t;

    localparam ph_idx_t PH_Q1 = ph_idx_t'(0);
    localparam ph_idx_t PH_Q2 = ph_idx_t'(1);
    localparam ph_idx_t PH_Q3 = ph_idx_t'(2);
    localparam ph_idx_t PH_Q4 = ph_idx_t'(3);
endpackage

// File: rtl/qseq_phase_gen.sv
// Phase generator: divides the input clock into NUM_PH one-hot strobes
// and a quarter-rate clock that is high for the first half of the cycle.
// Assumes the synchronous reset holds the counter at Q1.
module qseq_phase_gen
    import qseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    output logic [NUM_PH-1:0] ph_strobe,
    output logic              clk_quarter
);
    localparam ph_idx_t LAST = ph_idx_t'(NUM_PH - 1);
    localparam ph_idx_t HALF = ph_idx_t'(NUM_PH / 2);

    ph_idx_t cnt;

    // Phase counter: Q1 -> Q2 -> Q3 -> Q4 -> Q1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= PH_Q1;
        else if (cnt == LAST)
            cnt <= PH_Q1;
        else
            cnt <= cnt + ph_idx_t'(1);
    end

    // One decoded strobe per phase.
    for (genvar i = 0; i < NUM_PH; i++) begin : g_strobe
        assign ph_strobe[i] = (cnt == ph_idx_t'(i));
    end

    // Quarter-rate clock: high for the first half of the phases.
    assign clk_quarter = (cnt < HALF);
endmodule

// File: rtl/qseq_pc.sv
// Program counter: steps by one at the end of Q1 when told to, or loads
// a branch target at the end of Q4. Wraps modulo 2**AW.
// Assumes step and load are never high together (they lie in different phases).
module qseq_pc #(
    parameter int AW        = 10,
    parameter int RESET_VEC = 1023
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          load,
    input  logic [AW-1:0] target,
    output logic [AW-1:0] pc
);
    // Program-counter register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc <= AW'(RESET_VEC);
        else if (load)
            pc <= target;
        else if (step)
            pc <= pc + AW'(1);
    end
endmodule

// File: rtl/qseq_pipe.sv
// Pipeline control: holds the instruction register and the live flag
// that tells whether the word in it executes in this cycle. Generates the
// per-phase strobes and the branch load.
// Assumes ph_q is one-hot with bit 0 = Q1.
module qseq_pipe
    import qseq_pkg::*;
#(
    parameter int IW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_PH-1:0] ph_q,
    input  logic [IW-1:0]     fetch_word,
    input  logic              branch_req,
    output logic [IW-1:0]     instr,
    output logic              live,
    output logic              pc_step,
    output logic              pc_load,
    output logic              ir_strobe,
    output logic              rd_strobe,
    output logic              wr_strobe
);
    logic at_q1, at_q2, at_q4;

    assign at_q1 = ph_q[PH_Q1];
    assign at_q2 = ph_q[PH_Q2];
    assign at_q4 = ph_q[PH_Q4];

    // A branch only counts at the end of an executing cycle.
    assign pc_load = at_q4 & live & branch_req;

    // Instruction register: captures the fetched word at the end of Q4.
    always_ff @(posedge clk) begin
        if (!rst_n)
            instr <= '0;
        else if (at_q4)
            instr <= fetch_word;
    end

    // Live flag: low after reset and for the cycle after a taken branch.
    always_ff @(posedge clk) begin
        if (!rst_n)
            live <= 1'b0;
        else if (at_q4)
            live <= ~pc_load;
    end

    // Strobes for the surrounding core, masked in non-executing cycles.
    always_comb begin
        pc_step   = at_q1 & live;
        ir_strobe = at_q4;
        rd_strobe = at_q2 & live;
        wr_strobe = at_q4 & live;
    end
endmodule

// File: rtl/qseq_core.sv
// Top of the four-phase sequencer. Phase generation, program counter and
// pipeline control are wired together here.
// Assumes program memory reads asynchronously and PM_WORDS is a power of two.
module qseq_core
    import qseq_pkg::*;
#(
    parameter int IW        = 12,
    parameter int PM_WORDS  = 1024,
    parameter int RESET_VEC = PM_WORDS - 1,
    localparam int AW       = $clog2(PM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [AW-1:0]     pm_addr,
    input  logic [IW-1:0]     pm_data,
    input  logic              br_taken,
    input  logic [AW-1:0]     br_target,
    output logic [NUM_PH-1:0] phase,
    output logic              clkout,
    output logic              pc_inc,
    output logic              ir_load,
    output logic [IW-1:0]     ir,
    output logic              exec_live,
    output logic              dm_rd,
    output logic              dm_wr
);
    logic pc_load;

    qseq_phase_gen u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .ph_strobe   (phase),
        .clk_quarter (clkout)
    );

    qseq_pipe #(.IW(IW)) u_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .ph_q       (phase),
        .fetch_word (pm_data),
        .branch_req (br_taken),
        .instr      (ir),
        .live       (exec_live),
        .pc_step    (pc_inc),
        .pc_load    (pc_load),
        .ir_strobe  (ir_load),
        .rd_strobe  (dm_rd),
        .wr_strobe  (dm_wr)
    );

    qseq_pc #(.AW(AW), .RESET_VEC(RESET_VEC)) u_pc (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (pc_inc),
        .load   (pc_load),
        .target (br_target),
        .pc     (pm_addr)
    );
endmodule

// File: rtl/qseq_chk.sv
// Assertion checker for qseq_core, attached through bind below.
// Assumes the same parameter values as the instance it is bound to.
module qseq_chk #(
    parameter int IW = 12,
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] pm_addr,
    input logic          br_taken,
    input logic [AW-1:0] br_target,
    input logic [3:0]    phase,
    input logic          clkout,
    input logic          pc_inc,
    input logic          ir_load,
    input logic [IW-1:0] ir,
    input logic          exec_live,
    input logic          dm_rd,
    input logic          dm_wr
);
    p_phase_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(phase) == 1);
    p_phase_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        phase[3] |=> phase[0]);
    p_phase_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        phase[0] |=> phase[1]);
    p_clkout_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clkout) |-> phase[0]);
    p_pc_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pc_inc |=> pm_addr == $past(pm_addr) + AW'(1));
    p_pc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase[1] || phase[2]) |=> $stable(pm_addr));
    p_ir_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ir_load |=> $stable(ir));
    p_rd_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dm_rd |-> (phase[1] && exec_live));
    p_wr_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dm_wr |-> (phase[3] && exec_live));
    p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase[3] && exec_live && br_taken) |=> (!exec_live && pm_addr == $past(br_target)));
    p_idle_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase[3] && !exec_live) |=> exec_live);
endmodule

bind qseq_core qseq_chk #(.IW(IW), .AW(AW)) u_chk (.*);

// File: tb/sim_qseq_core.sv
// Bench for qseq_core: a table of per-cycle vectors walked by one loop,
// then directed reset tests. Checks are made on falling edges.
module sim_qseq_core;
    localparam int IW = 12;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] pm_addr;
    logic [IW-1:0] pm_data;
    logic          br_taken = 1'b0;
    logic [AW-1:0] br_target = '0;
    logic [3:0]    phase;
    logic          clkout, pc_inc, ir_load, exec_live, dm_rd, dm_wr;
    logic [IW-1:0] ir;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;   // 50 MHz

    // Program-memory model: the word is a function of its address.
    function automatic logic [IW-1:0] word_at(input logic [AW-1:0] a);
        return {2'b10, a} ^ 12'h0A5;
    endfunction
    assign pm_data = word_at(pm_addr);

    qseq_core u0 (
        .clk(clk), .rst_n(rst_n), .pm_addr(pm_addr), .pm_data(pm_data),
        .br_taken(br_taken), .br_target(br_target), .phase(phase),
        .clkout(clkout), .pc_inc(pc_inc), .ir_load(ir_load), .ir(ir),
        .exec_live(exec_live), .dm_rd(dm_rd), .dm_wr(dm_wr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Per-cycle vector: {br, target, live, check_ir, ir_addr, fetch_addr}
    localparam int NV = 13;
    localparam logic [32:0] VEC [NV] = '{
        {1'b1, 10'h055, 1'b0, 1'b0, 10'h000, 10'h3FF}, // 0 fetch-only, branch ignored R7 R9
        {1'b0, 10'h000, 1'b1, 1'b1, 10'h3FF, 10'h000}, // 1 wrap to 0 R4
        {1'b1, 10'h120, 1'b1, 1'b1, 10'h000, 10'h001}, // 2 branch R8
        {1'b1, 10'h200, 1'b0, 1'b1, 10'h001, 10'h120}, // 3 flush, branch ignored R9
        {1'b0, 10'h000, 1'b1, 1'b1, 10'h120, 10'h121}, // 4 target executes R8
        {1'b1, 10'h3FE, 1'b1, 1'b1, 10'h121, 10'h122}, // 5 branch R8
        {1'b0, 10'h000, 1'b0, 1'b1, 10'h122, 10'h3FE}, // 6 flush
        {1'b1, 10'h010, 1'b1, 1'b1, 10'h3FE, 10'h3FF}, // 7 branch right after target
        {1'b0, 10'h000, 1'b0, 1'b1, 10'h3FF, 10'h010}, // 8 flush
        {1'b1, 10'h011, 1'b1, 1'b1, 10'h010, 10'h011}, // 9 branch to next address
        {1'b0, 10'h000, 1'b0, 1'b1, 10'h011, 10'h011}, // 10 flush, PC not stepped
        {1'b0, 10'h000, 1'b1, 1'b1, 10'h011, 10'h012}, // 11 R10
        {1'b0, 10'h000, 1'b1, 1'b1, 10'h012, 10'h013}  // 12 R10
    };

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R3: reset state while reset is held
        chk(phase == 4'b0001, "R3", "phase in reset", phase, 1);
        chk(pm_addr == 10'h3FF, "R3", "pm_addr in reset", pm_addr, 10'h3FF);
        chk(!exec_live, "R3", "exec_live in reset", exec_live, 0);
        chk(ir == '0, "R3", "ir in reset", ir, 0);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            logic [32:0] v;
            v = VEC[k];
            br_taken  = v[32];
            br_target = v[31:22];
            for (int p = 0; p < 4; p++) begin
                chk(phase == 4'(1 << p), "R1", "phase", phase, 1 << p);
                chk(clkout == (p < 2), "R2", "clkout", clkout, p < 2);
                chk(exec_live == v[21], "R8", "exec_live", exec_live, v[21]);
                chk(pc_inc == (v[21] && p == 0), "R4", "pc_inc", pc_inc, v[21] && p == 0);
                chk(ir_load == (p == 3), "R5", "ir_load", ir_load, p == 3);
                chk(dm_rd == (v[21] && p == 1), "R6", "dm_rd", dm_rd, v[21] && p == 1);
                chk(dm_wr == (v[21] && p == 3), "R6", "dm_wr", dm_wr, v[21] && p == 3);
                if (p > 0)
                    chk(pm_addr == v[9:0], "R4", "pm_addr fetch", pm_addr, v[9:0]);
                if (v[20])
                    chk(ir == word_at(v[19:10]), "R10", "ir word", ir, word_at(v[19:10]));
                @(negedge clk);
            end
        end
        br_taken = 1'b0;

        // R3: reset applied mid-cycle returns to Q1 and the reset vector
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(phase == 4'b0001, "R3", "phase after mid reset", phase, 1);
        chk(pm_addr == 10'h3FF, "R3", "pm_addr after mid reset", pm_addr, 10'h3FF);
        chk(!exec_live, "R3", "exec_live after mid reset", exec_live, 0);
        chk(ir == '0, "R3", "ir after mid reset", ir, 0);
        @(negedge clk);
        chk(phase == 4'b0001, "R3", "phase held in reset", phase, 1);
        rst_n = 1'b1;

        // R7: fetch-only cycle, then the reset-vector word executes
        for (int p = 0; p < 4; p++) begin
            chk(!pc_inc && !dm_rd && !dm_wr, "R7", "strobes in fetch-only cycle",
                {pc_inc, dm_rd, dm_wr}, 0);
            @(negedge clk);
        end
        chk(exec_live, "R7", "exec_live after fetch-only cycle", exec_live, 1);
        chk(ir == word_at(10'h3FF), "R7", "first word", ir, word_at(10'h3FF));
        chk(pc_inc, "R4", "pc_inc in Q1", pc_inc, 1);
        @(negedge clk);
        chk(pm_addr == 10'h000, "R4", "wrap after reset", pm_addr, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule